// File: doc/BRIEF.md
# Counted-Loop Branch Controller

This block resolves the closing branch of a software-pipelined counted loop. It keeps two counters: one for the iterations still to start and one for the pipeline stages still to drain. Either counter is loaded through a small write port. Each branch strobe does three things:

- It tests both counters and steps the right one down.
- It reports whether the branch is taken.
- It tells the surrounding core whether to rotate its registers, and which stage-valid bit to shift into the lowest rotating predicate.

Once the iteration count is exhausted, the controller keeps the loop going while the drain counter is above one. During that phase it feeds zeros into the predicates so that the later stages switch off one by one. Two branch flavours share the counter behaviour. The continue flavour is taken while the loop goes on. The exit flavour is taken when the loop ends.

All response outputs are registered and appear in the cycle after the strobe. The counter values are visible on dedicated outputs.

Top module: `loop_branch_ctrl`

## Requirements
- R1: After reset both counters read 0, and resp_valid_o, taken_o, rotate_o and stage_bit_o are 0.
- R2: A write with wr_sel_i=0 loads the iteration counter from wr_data_i. A write with wr_sel_i=1 loads the drain counter from the low bits of wr_data_i. The other counter is left unchanged.
- R3: On a strobe with a non-zero iteration counter, the iteration counter decrements by 1 and the drain counter holds. The response has rotate_o=1 and stage_bit_o=1.
- R4: On a strobe with the iteration counter at 0 and the drain counter above 1, the drain counter decrements by 1. The response has rotate_o=1 and stage_bit_o=0.
- R5: On a strobe with the iteration counter at 0 and the drain counter at 1 or 0, the drain counter becomes 0. The response has rotate_o=0 and stage_bit_o=0.
- R6: With br_kind_i=0 (continue flavour), taken_o equals rotate_o.
- R7: With br_kind_i=1 (exit flavour), taken_o is the inverse of rotate_o. Counter updates are identical to the continue flavour.
- R8: When a write and a strobe occur in the same cycle, the write is applied and the strobe is discarded. No response is produced and neither counter is decremented.
- R9: resp_valid_o pulses for exactly the one cycle after each accepted strobe. taken_o, rotate_o and stage_bit_o are 0 whenever resp_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Counter write strobe |
| wr_sel_i | input | 1 | Write target: 0 = iteration counter, 1 = drain counter |
| wr_data_i | input | LC_W | Write data |
| br_i | input | 1 | Loop-branch strobe |
| br_kind_i | input | 1 | Branch flavour: 0 = continue, 1 = exit |
| resp_valid_o | output | 1 | Response valid, one cycle after an accepted strobe |
| taken_o | output | 1 | Branch taken |
| rotate_o | output | 1 | Step the rename base down by one |
| stage_bit_o | output | 1 | Bit to shift into the lowest rotating predicate |
| loop_cnt_o | output | LC_W | Current iteration counter |
| epi_cnt_o | output | EC_W | Current drain counter |

## Verification
The bench walks a full loop through its steady state, drain and exit, first with the continue flavour and then with the exit flavour.

- At the drain boundary, a design that treats a drain count of 1 as "keep going" would rotate once too often after the loop ends.
- A repeated strobe at zero counts catches an underflow that would wrap the drain counter to all ones.
- A write colliding with a strobe exposes a design that decrements the freshly written value or emits a spurious response.
- A design that swaps the flavour polarity reports the wrong taken_o on every response.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef enum logic {
    BR_CONT = 1'b0,
    BR_EXIT = 1'b1
  } br_kind_e;

  typedef struct packed {
    logic valid;
    logic taken;
    logic rotate;
    logic stage_bit;
  } br_resp_t;
endpackage

// File: rtl/lbc_decide.sv
module lbc_decide #(
  parameter int LC_W = 16,
  parameter int EC_W = 8
) (
  input  logic [LC_W-1:0] lc_i,
  input  logic [EC_W-1:0] ec_i,
  output logic            cont_o,
  output logic            stage_bit_o,
  output logic [LC_W-1:0] lc_nx_o,
  output logic [EC_W-1:0] ec_nx_o
);
  localparam logic [EC_W-1:0] EcOne = EC_W'(1);

  always_comb begin
    lc_nx_o     = lc_i;
    ec_nx_o     = ec_i;
    cont_o      = 1'b0;
    stage_bit_o = 1'b0;
    if (lc_i != '0) begin
      lc_nx_o     = lc_i - LC_W'(1);
      cont_o      = 1'b1;
      stage_bit_o = 1'b1;
    end else if (ec_i > EcOne) begin
      ec_nx_o = ec_i - EcOne;
      cont_o  = 1'b1;
    end else begin
      ec_nx_o = '0; // final drain step, or already empty
    end
  end

  always_comb begin
    a_bit_needs_cont_r3: assert (!stage_bit_o || cont_o);
  end
endmodule

// File: rtl/lbc_counters.sv
module lbc_counters #(
  parameter int LC_W = 16,
  parameter int EC_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [LC_W-1:0] wr_data_i,
  input  logic            br_go_i,
  input  logic [LC_W-1:0] lc_nx_i,
  input  logic [EC_W-1:0] ec_nx_i,
  output logic [LC_W-1:0] lc_o,
  output logic [EC_W-1:0] ec_o
);
  logic [LC_W-1:0] lc_q;
  logic [EC_W-1:0] ec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lc_q <= '0;
      ec_q <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i) ec_q <= wr_data_i[EC_W-1:0];
      else          lc_q <= wr_data_i;
    end else if (br_go_i) begin
      lc_q <= lc_nx_i;
      ec_q <= ec_nx_i;
    end
  end

  assign lc_o = lc_q;
  assign ec_o = ec_q;

  p_lc_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_go_i && !wr_en_i && lc_q != '0) |=> (lc_q == $past(lc_q) - LC_W'(1)) && $stable(ec_q));
  p_ec_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_go_i && !wr_en_i && lc_q == '0 && ec_q > EC_W'(1)) |=> ec_q == $past(ec_q) - EC_W'(1));
  p_ec_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_go_i && !wr_en_i && lc_q == '0 && ec_q <= EC_W'(1)) |=> ec_q == '0);
  p_wr_lc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> (lc_q == $past(wr_data_i)) && $stable(ec_q));
  p_wr_ec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> (ec_q == $past(wr_data_i[EC_W-1:0])) && $stable(lc_q));
endmodule

// File: rtl/lbc_resp_reg.sv
module lbc_resp_reg
  import lbc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     br_go_i,
  input  br_kind_e kind_i,
  input  logic     cont_i,
  input  logic     stage_bit_i,
  output br_resp_t resp_o
);
  br_resp_t resp_q;
  logic     kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q <= '0;
      kind_q <= 1'b0;
    end else begin
      kind_q <= kind_i;
      if (br_go_i) begin
        resp_q.valid     <= 1'b1;
        resp_q.rotate    <= cont_i;
        resp_q.stage_bit <= stage_bit_i;
        resp_q.taken     <= (kind_i == BR_EXIT) ? !cont_i : cont_i;
      end else begin
        resp_q <= '0;
      end
    end
  end

  assign resp_o = resp_q;

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_q.valid |-> !(resp_q.taken || resp_q.rotate || resp_q.stage_bit));
  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_go_i |=> !resp_q.valid);
  p_flavour_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_q.valid |-> (resp_q.taken == (resp_q.rotate ^ kind_q)));
  p_bit_rot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_q.stage_bit |-> resp_q.rotate);
endmodule

// File: rtl/loop_branch_ctrl.sv
module loop_branch_ctrl
  import lbc_pkg::*;
#(
  parameter int LC_W = 16,
  parameter int EC_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [LC_W-1:0] wr_data_i,
  input  logic            br_i,
  input  logic            br_kind_i,
  output logic            resp_valid_o,
  output logic            taken_o,
  output logic            rotate_o,
  output logic            stage_bit_o,
  output logic [LC_W-1:0] loop_cnt_o,
  output logic [EC_W-1:0] epi_cnt_o
);
  logic            br_go;
  logic            cont;
  logic            sbit;
  logic [LC_W-1:0] lc, lc_nx;
  logic [EC_W-1:0] ec, ec_nx;
  br_resp_t        resp;

  assign br_go = br_i && !wr_en_i; // write wins a collision

  lbc_decide #(.LC_W(LC_W), .EC_W(EC_W)) u_decide (
    .lc_i(lc), .ec_i(ec), .cont_o(cont), .stage_bit_o(sbit),
    .lc_nx_o(lc_nx), .ec_nx_o(ec_nx)
  );

  lbc_counters #(.LC_W(LC_W), .EC_W(EC_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .br_go_i(br_go), .lc_nx_i(lc_nx), .ec_nx_i(ec_nx),
    .lc_o(lc), .ec_o(ec)
  );

  lbc_resp_reg u_resp (
    .clk_i(clk_i), .rst_ni(rst_ni), .br_go_i(br_go),
    .kind_i(br_kind_e'(br_kind_i)), .cont_i(cont), .stage_bit_i(sbit),
    .resp_o(resp)
  );

  assign resp_valid_o = resp.valid;
  assign taken_o      = resp.taken;
  assign rotate_o     = resp.rotate;
  assign stage_bit_o  = resp.stage_bit;
  assign loop_cnt_o   = lc;
  assign epi_cnt_o    = ec;

  p_collide_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && br_i) |=> !resp_valid_o);

  initial begin
    a_widths_r2: assert (EC_W <= LC_W && EC_W > 1);
  end
endmodule

// File: tb/sim_loop_branch_ctrl.sv
module sim_loop_branch_ctrl;
  localparam int LC_W = 16;
  localparam int EC_W = 8;
  localparam int NV   = 19;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            wr_en = 1'b0, wr_sel = 1'b0, br = 1'b0, kind = 1'b0;
  logic [LC_W-1:0] wr_data = '0;
  logic            v, t, r, b;
  logic [LC_W-1:0] lc;
  logic [EC_W-1:0] ec;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  loop_branch_ctrl #(.LC_W(LC_W), .EC_W(EC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .br_i(br), .br_kind_i(kind),
    .resp_valid_o(v), .taken_o(t), .rotate_o(r), .stage_bit_o(b),
    .loop_cnt_o(lc), .epi_cnt_o(ec)
  );

  // {op[1:0] 0 idle/1 wr lc/2 wr ec/3 branch, kind, data[7:0], exp {v,t,r,b}, exp lc[7:0], exp ec[7:0]}
  localparam logic [30:0] TAB [NV] = '{
    {2'd1, 1'b0, 8'd2,   4'b0000, 8'd2,   8'd0}, // R2
    {2'd2, 1'b0, 8'd3,   4'b0000, 8'd2,   8'd3}, // R2
    {2'd3, 1'b0, 8'd0,   4'b1111, 8'd1,   8'd3}, // R3 R6
    {2'd3, 1'b0, 8'd0,   4'b1111, 8'd0,   8'd3}, // R3
    {2'd3, 1'b0, 8'd0,   4'b1110, 8'd0,   8'd2}, // R4
    {2'd3, 1'b0, 8'd0,   4'b1110, 8'd0,   8'd1}, // R4
    {2'd3, 1'b0, 8'd0,   4'b1000, 8'd0,   8'd0}, // R5 R6
    {2'd3, 1'b0, 8'd0,   4'b1000, 8'd0,   8'd0}, // R5 no underflow
    {2'd0, 1'b0, 8'd0,   4'b0000, 8'd0,   8'd0}, // R9
    {2'd1, 1'b0, 8'd1,   4'b0000, 8'd1,   8'd0}, // R2
    {2'd2, 1'b0, 8'd2,   4'b0000, 8'd1,   8'd2}, // R2
    {2'd3, 1'b1, 8'd0,   4'b1011, 8'd0,   8'd2}, // R7
    {2'd3, 1'b1, 8'd0,   4'b1010, 8'd0,   8'd1}, // R7
    {2'd3, 1'b1, 8'd0,   4'b1100, 8'd0,   8'd0}, // R7 exit taken
    {2'd0, 1'b0, 8'd0,   4'b0000, 8'd0,   8'd0}, // R9
    {2'd2, 1'b0, 8'd1,   4'b0000, 8'd0,   8'd1}, // R2
    {2'd3, 1'b1, 8'd0,   4'b1100, 8'd0,   8'd0}, // R5 R7
    {2'd1, 1'b0, 8'd200, 4'b0000, 8'd200, 8'd0}, // R2
    {2'd3, 1'b0, 8'd0,   4'b1111, 8'd199, 8'd0}  // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [3:0] e_resp,
                         input logic [LC_W-1:0] e_lc, input logic [EC_W-1:0] e_ec);
    chk({req, " resp"}, 32'({v, t, r, b}), 32'(e_resp));
    chk({req, " loop_cnt"}, 32'(lc), 32'(e_lc));
    chk({req, " epi_cnt"}, 32'(ec), 32'(e_ec));
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_sel = 1'b0; br = 1'b0; kind = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1", 4'b0000, '0, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      idle_inputs();
      case (TAB[i][30:29])
        2'd1: begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = LC_W'(TAB[i][27:20]); end
        2'd2: begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = LC_W'(TAB[i][27:20]); end
        2'd3: begin br = 1'b1; kind = TAB[i][28]; end
        default: ;
      endcase
      @(negedge clk);
      chk_all($sformatf("vec%0d", i), TAB[i][19:16], LC_W'(TAB[i][15:8]), TAB[i][7:0]);
    end

    // R8: write and strobe collide, write wins
    idle_inputs();
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'd5;
    @(negedge clk);
    wr_data = 16'd9; br = 1'b1;
    @(negedge clk);
    chk_all("R8 lc collide", 4'b0000, 16'd9, 8'd0);
    idle_inputs();
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'd4; br = 1'b1;
    @(negedge clk);
    chk_all("R8 ec collide", 4'b0000, 16'd9, 8'd4);
    idle_inputs();
    br = 1'b1;
    @(negedge clk);
    chk_all("R8 next strobe R3", 4'b1111, 16'd8, 8'd4);
    idle_inputs();
    @(negedge clk);
    chk_all("R9 pulse ends", 4'b0000, 16'd8, 8'd4);

    // R1: reset mid-run
    rst_ni = 1'b0;
    @(negedge clk);
    chk_all("R1 mid-run reset", 4'b0000, '0, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule